// File: doc/BRIEF.md
# Strobe-Framed Serial Panel Command Port

This block is the host-facing serial port of a segment display and keypad controller. A host talks to it over three wires: a shift clock, an active-low strobe that frames each transfer, and one data line that the port samples in write mode and pulls low in read mode. Every frame opens with a command byte. The byte either sets up the display engine (multiplex duty, frame divider, bias source, master or slave role, test mode) or sets the port's status (write or read direction, display on or off, which latch row the next payload goes to).

In write mode, the bits that follow the command form a 56-bit segment payload. When the strobe rises, the payload is committed to one row of a four-row output latch. In read mode, the port instead shifts the 32-bit key latch out to the host, most significant bit first. The port produces the decoded mode outputs, the latch contents and the current read index into the key latch. The analog drivers, the oscillator and the physical pad sit outside it. Shift clock, strobe and data are sampled into the system clock domain, so the serial clock must be several system clocks slow.

Top module: `panel_serial_port`

## Requirements
- R1: After reset all setup fields are 0 (duty code 0 giving 4 rows, divider 128, internal bias, master, test off). The display is off, key scan is stopped, the port is in write mode at row 0, every latch row is 0, the data line is released and the key read index is 31.
- R2: The first 8 bits sampled on rising shift clock edges after the strobe falls form the command, most significant bit first. Bits 9 to 64 are segment bits: the first of them lands in latch row bit 0 (segment 1), the last in bit 55 (segment 56).
- R3: A command with bit 7 = 0 is a setup command. Bits 1:0 give the number of active rows (00 → 4, 01 → 3, 10 or 11 → 2). Bits 3:2 give the frame divider 128 × 2^code. Bit 4 = 1 selects external bias, bit 5 = 1 selects slave, bit 6 = 1 enables test mode.
- R4: A setup command whose bits 6:0 differ from the stored setup turns the display off and stops key scan. One that equals the stored setup changes nothing.
- R5: A command with bit 7 = 1 is a status command. Bits 4:3 give the latch row, and bit 0 = 1 selects read mode (0 = write). Bits 2:1 control the display: 10 turns the display and key scan on, 00 turns both off, and 01 or 11 leave them unchanged.
- R6: In write mode, a row is written only when the strobe rises after all 56 segment bits have arrived. A shorter payload leaves every row unchanged. Bits after the 56th are ignored.
- R7: In read mode, each falling shift clock edge after the command byte drives the next key bit, starting at bit 31. The line is pulled low (`sdo_pull_o` = 1) exactly when that bit is 0. After 32 bits, and whenever the strobe is high, the line is released.
- R8: A strobe rise in the middle of a byte discards that partial byte. A command completed earlier in the same frame stays applied. The next frame starts again with a command byte.
- R9: During a read frame, `key_ptr_o` gives the index of the key bit driven next: 31 after the command, then one lower after each rising shift clock edge, and 0 once all 32 bits have gone out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial shift clock, idles high |
| stb_i | input | 1 | Frame strobe, active low |
| sdi_i | input | 1 | Serial data line as seen at the pad |
| key_i | input | 32 | Key latch contents to be read out |
| sdo_pull_o | output | 1 | 1 pulls the data line low (open-drain drive) |
| duty_sel_o | output | 2 | Stored duty code |
| com_rows_o | output | 3 | Number of active rows decoded from the duty code |
| frame_div_o | output | 11 | Decoded frame divider |
| bias_ext_o | output | 1 | External bias selected |
| slave_o | output | 1 | Slave role selected |
| test_o | output | 1 | Test mode enabled |
| disp_on_o | output | 1 | Display enabled |
| key_scan_o | output | 1 | Key scan running |
| read_mode_o | output | 1 | Port in key read mode |
| row_addr_o | output | 2 | Latch row selected by the last status command |
| key_ptr_o | output | 5 | Index of the next key bit to be driven |
| latch_o | output | 224 | Latch rows; row r occupies bits r×56 to r×56+55 |

## Verification
The hardest case to reach from the ports is an abort that lands inside a byte. The strobe has to rise after a few bits of a command, or part-way through a segment payload, and the port must keep the command that already completed while dropping both the partial byte and the uncommitted row. The bench reaches it by driving the wires bit by bit from tasks: it stops a frame after five command bits, and again after twenty payload bits, then inspects the setup outputs, the row address and the latch. Read frames get the same per-bit control, so the pull level and the read index are checked in the low half of every shift clock period.

// File: rtl/panel_port_pkg.sv
package panel_port_pkg;

  typedef struct packed {
    logic       test_en;
    logic       slave;
    logic       bias_ext;
    logic [1:0] frame_code;
    logic [1:0] duty_code;
  } setup_t;

  // Active rows for a duty code
  function automatic logic [2:0] duty_rows(input logic [1:0] code);
    case (code)
      2'b00:   return 3'd4;
      2'b01:   return 3'd3;
      default: return 3'd2;
    endcase
  endfunction

  // Frame divider: 128 doubled once per code step
  function automatic logic [10:0] frame_divisor(input logic [1:0] code);
    return 11'd128 << code;
  endfunction

endpackage

// File: rtl/port_sync.sv
module port_sync #(
  parameter logic RST_VAL = 1'b1,
  parameter int   STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/port_cmd_decode.sv
module port_cmd_decode
  import panel_port_pkg::*;
#(
  parameter int CMD_W = 8,
  parameter int ROW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_ev,
  input  logic [CMD_W-1:0] cmd_byte,
  output setup_t           setup_q,
  output logic             disp_on_q,
  output logic             key_scan_q,
  output logic             read_q,
  output logic [ROW_W-1:0] row_q
);
  logic is_status, setup_differs;

  assign is_status     = cmd_byte[CMD_W-1];
  assign setup_differs = (setup_t'(cmd_byte[6:0]) != setup_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q    <= '0;
      disp_on_q  <= 1'b0;
      key_scan_q <= 1'b0;
      read_q     <= 1'b0;
      row_q      <= '0;
    end else if (cmd_ev) begin
      if (!is_status) begin
        if (setup_differs) begin
          setup_q    <= setup_t'(cmd_byte[6:0]);
          disp_on_q  <= 1'b0;
          key_scan_q <= 1'b0;
        end
      end else begin
        row_q  <= cmd_byte[3 +: ROW_W];
        read_q <= cmd_byte[0];
        case (cmd_byte[2:1])
          2'b10: begin disp_on_q <= 1'b1; key_scan_q <= 1'b1; end
          2'b00: begin disp_on_q <= 1'b0; key_scan_q <= 1'b0; end
          default: ;
        endcase
      end
    end
  end

  assert_setup_forces_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ev && !is_status && setup_differs) |=> (!disp_on_q && !key_scan_q));

  assert_same_setup_inert_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ev && !is_status && !setup_differs) |=> ($stable(disp_on_q) && $stable(setup_q)));

  assert_on_only_by_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disp_on_q) |-> $past(cmd_ev && is_status));
endmodule

// File: rtl/port_row_latch.sv
module port_row_latch #(
  parameter int SEG_W = 56,
  parameter int ROWS  = 4,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  commit,
  input  logic [ROW_W-1:0]      row_sel,
  input  logic [SEG_W-1:0]      seg_data,
  output logic [ROWS*SEG_W-1:0] rows_flat
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rows_flat[r*SEG_W +: SEG_W] <= '0;
      else if (commit && row_sel == ROW_W'(r))
        rows_flat[r*SEG_W +: SEG_W] <= seg_data;
    end
  end

  assert_rows_hold_without_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(rows_flat));
endmodule

// File: rtl/panel_serial_port.sv
module panel_serial_port
  import panel_port_pkg::*;
#(
  parameter int SEG_W = 56,
  parameter int ROWS  = 4,
  parameter int CMD_W = 8,
  parameter int KEY_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sck_i,
  input  logic                  stb_i,
  input  logic                  sdi_i,
  input  logic [KEY_W-1:0]      key_i,
  output logic                  sdo_pull_o,
  output logic [1:0]            duty_sel_o,
  output logic [2:0]            com_rows_o,
  output logic [10:0]           frame_div_o,
  output logic                  bias_ext_o,
  output logic                  slave_o,
  output logic                  test_o,
  output logic                  disp_on_o,
  output logic                  key_scan_o,
  output logic                  read_mode_o,
  output logic [$clog2(ROWS)-1:0]  row_addr_o,
  output logic [$clog2(KEY_W)-1:0] key_ptr_o,
  output logic [ROWS*SEG_W-1:0] latch_o
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int FULL  = CMD_W + SEG_W;
  localparam int CNT_W = $clog2(FULL + 1);
  localparam int RD_W  = $clog2(KEY_W + 1);
  localparam int PTR_W = $clog2(KEY_W);
  localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(KEY_W - 1);

  // Synchronized pad signals: [0] shift clock, [1] strobe, [2] data
  logic [2:0] pad_raw, pad_q;
  assign pad_raw = {sdi_i, stb_i, sck_i};

  for (genvar gi = 0; gi < 3; gi++) begin : g_sync
    port_sync #(.RST_VAL(1'b1), .STAGES(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(pad_raw[gi]), .q(pad_q[gi]));
  end

  logic sck_d, stb_d;
  logic sck_rise, sck_fall, stb_rise, stb_fall, sdi;
  assign sck_rise = pad_q[0] & ~sck_d;
  assign sck_fall = ~pad_q[0] & sck_d;
  assign stb_rise = pad_q[1] & ~stb_d;
  assign stb_fall = ~pad_q[1] & stb_d;
  assign sdi      = pad_q[2];

  logic             in_frame, sdo_pull_q;
  logic [CNT_W-1:0] bit_cnt;
  logic [RD_W-1:0]  rd_cnt;
  logic [CMD_W-2:0] cmd_sr;
  logic [SEG_W-1:0] seg_sr;
  logic             in_cmd, rd_done;
  logic [PTR_W-1:0] key_idx;

  // Named events shared by the decode, the latch and the assertions
  logic             cmd_ev, commit_ev;
  logic [CMD_W-1:0] cmd_byte;

  setup_t           setup_q;
  logic             disp_on_q, key_scan_q, read_q;
  logic [ROW_W-1:0] row_q;

  assign in_cmd   = bit_cnt < CNT_W'(CMD_W);
  assign rd_done  = rd_cnt == RD_W'(KEY_W);
  assign key_idx  = PTR_TOP - rd_cnt[PTR_W-1:0];
  assign cmd_byte = {cmd_sr, sdi};
  assign cmd_ev   = in_frame && !stb_rise && !stb_fall && sck_rise &&
                    (bit_cnt == CNT_W'(CMD_W - 1));
  assign commit_ev = stb_rise && in_frame && !read_q && (bit_cnt == CNT_W'(FULL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d      <= 1'b1;
      stb_d      <= 1'b1;
      in_frame   <= 1'b0;
      bit_cnt    <= '0;
      rd_cnt     <= '0;
      cmd_sr     <= '0;
      seg_sr     <= '0;
      sdo_pull_q <= 1'b0;
    end else begin
      sck_d <= pad_q[0];
      stb_d <= pad_q[1];
      if (stb_fall) begin
        in_frame   <= 1'b1;
        bit_cnt    <= '0;
        rd_cnt     <= '0;
        sdo_pull_q <= 1'b0;
      end else if (stb_rise) begin
        in_frame   <= 1'b0;
        sdo_pull_q <= 1'b0;
      end else if (in_frame) begin
        if (sck_rise) begin
          if (in_cmd) begin
            cmd_sr  <= {cmd_sr[CMD_W-3:0], sdi};
            bit_cnt <= bit_cnt + CNT_W'(1);
          end else if (read_q) begin
            if (!rd_done) rd_cnt <= rd_cnt + RD_W'(1);
          end else if (bit_cnt != CNT_W'(FULL)) begin
            seg_sr  <= {sdi, seg_sr[SEG_W-1:1]};
            bit_cnt <= bit_cnt + CNT_W'(1);
          end
        end
        if (sck_fall && !in_cmd && read_q)
          sdo_pull_q <= !rd_done && !key_i[key_idx];
      end
    end
  end

  port_cmd_decode #(.CMD_W(CMD_W), .ROW_W(ROW_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .cmd_ev(cmd_ev), .cmd_byte(cmd_byte),
    .setup_q(setup_q), .disp_on_q(disp_on_q), .key_scan_q(key_scan_q),
    .read_q(read_q), .row_q(row_q));

  port_row_latch #(.SEG_W(SEG_W), .ROWS(ROWS)) u_latch (
    .clk(clk), .rst_n(rst_n), .commit(commit_ev), .row_sel(row_q),
    .seg_data(seg_sr), .rows_flat(latch_o));

  assign sdo_pull_o  = sdo_pull_q;
  assign duty_sel_o  = setup_q.duty_code;
  assign com_rows_o  = duty_rows(setup_q.duty_code);
  assign frame_div_o = frame_divisor(setup_q.frame_code);
  assign bias_ext_o  = setup_q.bias_ext;
  assign slave_o     = setup_q.slave;
  assign test_o      = setup_q.test_en;
  assign disp_on_o   = disp_on_q;
  assign key_scan_o  = key_scan_q;
  assign read_mode_o = read_q;
  assign row_addr_o  = row_q;
  assign key_ptr_o   = rd_done ? '0 : key_idx;

  assert_release_on_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stb_rise |=> !sdo_pull_q);

  assert_pull_only_reading_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_pull_q |-> read_q);

  assert_count_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FULL));

  assert_abort_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stb_fall |=> (bit_cnt == '0 && !sdo_pull_q));
endmodule

// File: tb/tb_panel_serial_port.sv
module tb_panel_serial_port;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b1, stb = 1'b1, sdi = 1'b1;
  logic [31:0] key = 32'h0;
  logic sdo_pull, bias_ext, slave, test_en, disp_on, key_scan, read_mode;
  logic [1:0] duty_sel, row_addr;
  logic [2:0] com_rows;
  logic [10:0] frame_div;
  logic [4:0] key_ptr;
  logic [223:0] latch;

  int checks = 0;
  int fails  = 0;
  logic [55:0] model [4];

  always #4 clk = ~clk;

  panel_serial_port dut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .stb_i(stb), .sdi_i(sdi), .key_i(key),
    .sdo_pull_o(sdo_pull), .duty_sel_o(duty_sel), .com_rows_o(com_rows),
    .frame_div_o(frame_div), .bias_ext_o(bias_ext), .slave_o(slave), .test_o(test_en),
    .disp_on_o(disp_on), .key_scan_o(key_scan), .read_mode_o(read_mode),
    .row_addr_o(row_addr), .key_ptr_o(key_ptr), .latch_o(latch));

  // Each vector: status command (write, display on, row in bits 4:3), then 56 segment bits
  localparam logic [63:0] VEC [5] = '{
    {8'h84, 56'h00_1234_5678_9ABC},
    {8'h8C, 56'hFF_0000_FFFF_0001},
    {8'h94, 56'h80_0000_0000_0001},
    {8'h9C, 56'hA5_A5A5_5A5A_5A5A},
    {8'h8C, 56'h3C_C3C3_3C3C_7E81}
  };

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    sck = 1'b0; sdi = b; wait_cyc(H);
    sck = 1'b1; wait_cyc(H);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic send_seg(input logic [63:0] d, input int n);
    for (int i = 0; i < n; i++) send_bit(d[i]);
  endtask

  task automatic frame_begin();
    stb = 1'b0; wait_cyc(2 * H);
  endtask

  task automatic frame_end();
    sdi = 1'b1; stb = 1'b1; wait_cyc(4 * H);
  endtask

  task automatic cmd_frame(input logic [7:0] c);
    frame_begin(); send_byte(c); frame_end();
  endtask

  task automatic chk_rows(input string what);
    for (int r = 0; r < 4; r++) chk(what, 64'(latch[r*56 +: 56]), 64'(model[r]));
  endtask

  // Independent restatement of the setup decode
  task automatic chk_setup(input string what, input logic [6:0] s);
    logic [2:0] rows_e;
    logic [10:0] div_e;
    rows_e = (s[1:0] == 2'b00) ? 3'd4 : (s[1:0] == 2'b01) ? 3'd3 : 3'd2;
    div_e  = 11'd128;
    for (int k = 0; k < 3; k++) if (k < int'(s[3:2])) div_e = div_e * 2;
    chk({what, " rows"}, 64'(com_rows), 64'(rows_e));
    chk({what, " divider"}, 64'(frame_div), 64'(div_e));
    chk({what, " bias"}, 64'(bias_ext), 64'(s[4]));
    chk({what, " slave"}, 64'(slave), 64'(s[5]));
    chk({what, " test"}, 64'(test_en), 64'(s[6]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int r = 0; r < 4; r++) model[r] = '0;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(3);

    // R1 reset state
    chk_setup("R1 reset", 7'h00);
    chk("R1 duty code", 64'(duty_sel), 64'd0);
    chk("R1 display off", 64'(disp_on), 64'd0);
    chk("R1 key scan off", 64'(key_scan), 64'd0);
    chk("R1 write mode", 64'(read_mode), 64'd0);
    chk("R1 row", 64'(row_addr), 64'd0);
    chk("R1 line released", 64'(sdo_pull), 64'd0);
    chk("R1 key index", 64'(key_ptr), 64'd31);
    chk_rows("R1 latch clear");

    // R2 R5 R6 vector table of full write frames
    foreach (VEC[v]) begin
      frame_begin();
      send_byte(VEC[v][63:56]);
      send_seg(64'(VEC[v][55:0]), 56);
      frame_end();
      model[VEC[v][60:59]] = VEC[v][55:0];
      chk("R2 row written", 64'(latch[int'(VEC[v][60:59])*56 +: 56]), 64'(VEC[v][55:0]));
      chk("R5 row address", 64'(row_addr), 64'(VEC[v][60:59]));
      chk("R5 display on", 64'(disp_on), 64'd1);
    end
    chk_rows("R2 all rows");

    // R3 R4 setup commands
    cmd_frame(8'h00);
    chk("R4 identical setup keeps display", 64'(disp_on), 64'd1);
    chk("R4 identical setup keeps scan", 64'(key_scan), 64'd1);
    cmd_frame(8'h5E);
    chk_setup("R3 setup 5E", 7'h5E);
    chk("R4 new setup display off", 64'(disp_on), 64'd0);
    chk("R4 new setup scan off", 64'(key_scan), 64'd0);
    cmd_frame(8'h84);
    cmd_frame(8'h21);
    chk_setup("R3 setup 21", 7'h21);
    chk("R4 setup 21 display off", 64'(disp_on), 64'd0);
    cmd_frame(8'h84);
    cmd_frame(8'h21);
    chk("R4 repeated setup keeps display", 64'(disp_on), 64'd1);
    cmd_frame(8'h07);
    chk_setup("R3 setup 07", 7'h07);
    chk("R3 duty code 3", 64'(duty_sel), 64'd3);
    cmd_frame(8'h00);
    chk_setup("R3 setup back to 00", 7'h00);
    cmd_frame(8'h84);

    // R5 display control codes
    cmd_frame(8'h82);
    chk("R5 code 01 no change", 64'(disp_on), 64'd1);
    cmd_frame(8'h80);
    chk("R5 code 00 display off", 64'(disp_on), 64'd0);
    chk("R5 code 00 scan off", 64'(key_scan), 64'd0);
    cmd_frame(8'h86);
    chk("R5 code 11 no change", 64'(disp_on), 64'd0);
    cmd_frame(8'h84);
    chk("R5 code 10 scan on", 64'(key_scan), 64'd1);

    // R6 short and long payloads
    frame_begin(); send_byte(8'h8C); send_seg(64'hFFFF_FFFF_FFFF_FFFF, 40); frame_end();
    chk_rows("R6 short payload ignored");
    frame_begin(); send_byte(8'h8C); send_seg(64'hF123_4567_89AB_CDEF, 60); frame_end();
    model[1] = 56'h23_4567_89AB_CDEF;
    chk_rows("R6 long payload truncated");

    // R8 aborts
    frame_begin(); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    send_bit(1'b1); frame_end();
    chk_setup("R8 partial command discarded", 7'h00);
    chk("R8 partial command display", 64'(disp_on), 64'd1);
    frame_begin(); send_byte(8'h9C); send_seg(64'h0, 20); frame_end();
    chk("R8 completed command kept", 64'(row_addr), 64'd3);
    chk_rows("R8 partial payload discarded");
    frame_begin(); send_byte(8'h9C); send_seg(64'h00_0F0F_0F0F_0F0F, 56); frame_end();
    model[3] = 56'h00_0F0F_0F0F_0F0F;
    chk_rows("R8 frame after abort");

    // R7 R9 key read
    key = 32'hA5C3_0F96;
    frame_begin();
    send_byte(8'h85);
    chk("R7 read mode", 64'(read_mode), 64'd1);
    for (int i = 0; i < 32; i++) begin
      sck = 1'b0; sdi = 1'b1; wait_cyc(H);
      chk("R9 key index", 64'(key_ptr), 64'(31 - i));
      chk("R7 key bit pull", 64'(sdo_pull), 64'(!key[31 - i]));
      sck = 1'b1; wait_cyc(H);
    end
    sck = 1'b0; wait_cyc(H);
    chk("R7 released after 32 bits", 64'(sdo_pull), 64'd0);
    chk("R9 index after 32 bits", 64'(key_ptr), 64'd0);
    sck = 1'b1; wait_cyc(H);
    frame_end();
    chk("R7 released with strobe high", 64'(sdo_pull), 64'd0);
    chk_rows("R7 read frame leaves latch");
    cmd_frame(8'h84);
    chk("R5 back to write mode", 64'(read_mode), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule